// File: doc/BRIEF.md
# Dual-Protocol Display Host Interface

This block is the host-facing capture stage of a display controller. A microprocessor talks to it over one shared set of pins. Two straps pick how those pins are read. The first choice is an Intel-8080-style parallel bus with separate active-low read and write strobes. The second is a Motorola-6800-style parallel bus with an active-high enable and a read/write line. The third is a clocked serial link that takes over the two top data pins. Each byte the host writes reaches the system clock domain as an 8-bit value, a data/command flag and a one-cycle valid pulse.

All host strobes are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are detected after it. A host read in either parallel mode drives the bus from a status/data byte that the surrounding logic supplies. The chip is addressed only when its active-low select is low and its active-high select is high together.

Top module: `dhi_top`

## Requirements
- R1: After reset, `byte_valid` and `bus_oe` are low and `bus_o` is zero, even while the strobes sit at their idle levels.
- R2: Bus activity counts only when `cs_n`=0 and `cs`=1. With (`cs_n`,`cs`) equal to (0,0), (1,0) or (1,1), writes produce no byte and reads leave `bus_oe` low.
- R3: With `strap_par`=1 and `strap_m68`=0, a rising edge on `wr_rw` (write strobe, active low) captures `bus_i` and `dc` as one byte.
- R4: With `strap_par`=1 and `strap_m68`=0, `bus_oe` is high and `bus_o` equals `rd_data` while `rd_e` (read strobe, active low) is low, three clocks behind the pins. Whenever `bus_oe` is low, `bus_o` is zero.
- R5: With `strap_par`=1 and `strap_m68`=1, a falling edge on `rd_e` (enable, active high) while `wr_rw`=0 (write) captures a byte. An enable pulse with `wr_rw`=1 produces no byte.
- R6: With `strap_par`=1 and `strap_m68`=1, `bus_oe` is high and `bus_o` equals `rd_data` while `rd_e`=1 and `wr_rw`=1. With `wr_rw`=0 the bus stays undriven.
- R7: With `strap_par`=0, `bus_i[6]` is the serial clock and `bus_i[7]` the serial data. Bits are taken on rising clock edges, most significant bit first. The eighth bit completes a byte, and `dc` is taken together with that bit. `bus_i[5:0]` have no effect, and `bus_oe` stays low.
- R8: Deselecting the chip in serial mode discards a partly received byte. The next eight bits form a whole byte.
- R9: The straps are taken only while reset is active. Changing them afterwards does not change the mode.
- R10: Each byte produces exactly one `byte_valid` pulse, one clock long, in the third clock after the completing strobe edge. `byte_is_data` is 1 for display data (`dc`=1) and 0 for a command (`dc`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_par | input | 1 | 1 = parallel bus, 0 = serial |
| strap_m68 | input | 1 | 1 = 6800-style, 0 = 8080-style parallel timing |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| rd_e | input | 1 | 8080: read strobe (low active); 6800: enable (high active) |
| wr_rw | input | 1 | 8080: write strobe (low active); 6800: 1 read, 0 write |
| dc | input | 1 | 1 = display data, 0 = command |
| bus_i | input | 8 | Data pins in; serial uses bit 6 as clock and bit 7 as data |
| bus_o | output | 8 | Data pins out during reads |
| bus_oe | output | 1 | Output enable for the data pins |
| rd_data | input | 8 | Byte returned on host reads |
| byte_valid | output | 1 | One-cycle pulse per received byte |
| byte_data | output | 8 | Received byte |
| byte_is_data | output | 1 | Data/command flag of the received byte |

## Verification
The bench sweeps all 256 byte values with both flag values through each write path. A design that dropped or swapped a bit, reversed the serial order or sampled `dc` at the wrong time would show a wrong byte at once. It walks the three deselected select combinations and expects neither a byte nor a driven bus. A design that checked only one select line would capture a byte or drive the bus there. It breaks off a serial byte with a deselect and expects the next eight bits to come out intact; a design that kept its bit count would shift leftovers into that byte. It also changes the straps after reset, fires enable pulses in the read direction, and pulls the 8080 read strobe low in serial mode. Each of these catches a design that follows live straps, captures on reads or drives the bus in serial mode.

// File: rtl/dhi_pkg.sv
package dhi_pkg;
  // Operating mode, fixed while reset is active.
  typedef enum logic [1:0] {
    MODE_I80 = 2'd0,
    MODE_M68 = 2'd1,
    MODE_SER = 2'd2
  } dhi_mode_t;

  // Offsets of the control lines above the data bits in the synchronized vector.
  localparam int OFS_CSN = 0;
  localparam int OFS_CS  = 1;
  localparam int OFS_RDE = 2;
  localparam int OFS_WRW = 3;
  localparam int OFS_DC  = 4;
  localparam int NCTL    = 5;
endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dhi_par_cap.sv
module dhi_par_cap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          m68,
  input  logic          sel,
  input  logic          rde_s,
  input  logic          wrw_s,
  input  logic [DW-1:0] data_s,
  input  logic          dc_s,
  output logic          v_q,
  output logic [DW-1:0] data_q,
  output logic          dc_q,
  output logic          oe_q
);
  logic          rde_prev, wrw_prev;
  logic          wr_edge_80, wr_edge_68, take, rd_act;
  logic          v_d, dc_d, oe_d;
  logic [DW-1:0] data_d;

  always_comb begin
    // 8080: write strobe returns high. 6800: enable falls with the line in write.
    wr_edge_80 = !m68 && wrw_s && !wrw_prev;
    wr_edge_68 = m68 && !rde_s && rde_prev && !wrw_s;
    take       = en && sel && (wr_edge_80 || wr_edge_68);
    rd_act     = en && sel && (m68 ? (rde_s && wrw_s) : !rde_s);
    v_d        = take;
    data_d     = take ? data_s : data_q;
    dc_d       = take ? dc_s : dc_q;
    oe_d       = rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rde_prev <= 1'b0;
      wrw_prev <= 1'b0;
      v_q      <= 1'b0;
      data_q   <= '0;
      dc_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      rde_prev <= rde_s;
      wrw_prev <= wrw_s;
      v_q      <= v_d;
      data_q   <= data_d;
      dc_q     <= dc_d;
      oe_q     <= oe_d;
    end
  end
endmodule

// File: rtl/dhi_ser_cap.sv
module dhi_ser_cap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic          dc_s,
  output logic          v_q,
  output logic [DW-1:0] data_q,
  output logic          dc_q
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sclk_prev, rise, last_bit;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] shf_q, shf_d, data_d;
  logic          v_d, dc_d;

  always_comb begin
    rise     = en && sel && sclk_s && !sclk_prev;
    last_bit = (cnt_q == LAST);
    cnt_d    = cnt_q;
    shf_d    = shf_q;
    v_d      = 1'b0;
    data_d   = data_q;
    dc_d     = dc_q;
    if (!sel) begin
      cnt_d = '0;
    end else if (rise) begin
      shf_d = {shf_q[DW-2:0], sdi_s};
      if (last_bit) begin
        cnt_d  = '0;
        v_d    = 1'b1;
        data_d = {shf_q[DW-2:0], sdi_s};
        dc_d   = dc_s;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      cnt_q     <= '0;
      shf_q     <= '0;
      v_q       <= 1'b0;
      data_q    <= '0;
      dc_q      <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      cnt_q     <= cnt_d;
      shf_q     <= shf_d;
      v_q       <= v_d;
      data_q    <= data_d;
      dc_q      <= dc_d;
    end
  end
endmodule

// File: rtl/dhi_top.sv
module dhi_top
  import dhi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_par,
  input  logic          strap_m68,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          rd_e,
  input  logic          wr_rw,
  input  logic          dc,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe,
  input  logic [DW-1:0] rd_data,
  output logic          byte_valid,
  output logic [DW-1:0] byte_data,
  output logic          byte_is_data
);
  localparam int SW   = DW + NCTL;
  localparam int WARM = SYNC_STAGES + 1;
  localparam int WCW  = $clog2(WARM + 1);
  localparam int SCLK_BIT = DW - 2;
  localparam int SDI_BIT  = DW - 1;

  // Reset: asserted at once, released on the clock.
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Mode is loaded only while reset is held.
  dhi_mode_t mode_d, mode_q;
  always_comb mode_d = strap_par ? (strap_m68 ? MODE_M68 : MODE_I80) : MODE_SER;
  always_ff @(posedge clk) begin
    if (!rst_q) mode_q <= mode_d;
  end

  logic [SW-1:0] raw, syn;
  assign raw = {dc, wr_rw, rd_e, cs, cs_n, bus_i};

  dhi_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .d(raw), .q(syn)
  );

  logic sel_s;
  assign sel_s = !syn[DW+OFS_CSN] && syn[DW+OFS_CS];

  // Edge detectors stay blind until the synchronizer holds real pin values.
  logic [WCW-1:0] warm_q, warm_d;
  logic           armed;
  always_comb begin
    armed  = (warm_q == WCW'(WARM));
    warm_d = armed ? warm_q : warm_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  logic          p_v, p_dc, p_oe, s_v, s_dc;
  logic [DW-1:0] p_data, s_data;

  dhi_par_cap #(.DW(DW)) u_par (
    .clk(clk), .rst_n(rst_q),
    .en(armed && (mode_q != MODE_SER)),
    .m68(mode_q == MODE_M68),
    .sel(sel_s),
    .rde_s(syn[DW+OFS_RDE]), .wrw_s(syn[DW+OFS_WRW]),
    .data_s(syn[DW-1:0]), .dc_s(syn[DW+OFS_DC]),
    .v_q(p_v), .data_q(p_data), .dc_q(p_dc), .oe_q(p_oe)
  );

  dhi_ser_cap #(.DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_q),
    .en(armed && (mode_q == MODE_SER)),
    .sel(sel_s),
    .sclk_s(syn[SCLK_BIT]), .sdi_s(syn[SDI_BIT]), .dc_s(syn[DW+OFS_DC]),
    .v_q(s_v), .data_q(s_data), .dc_q(s_dc)
  );

  always_comb begin
    byte_valid   = p_v || s_v;
    byte_data    = (mode_q == MODE_SER) ? s_data : p_data;
    byte_is_data = (mode_q == MODE_SER) ? s_dc : p_dc;
    bus_oe       = p_oe;
    bus_o        = p_oe ? rd_data : '0;
  end
endmodule

// File: rtl/dhi_checker.sv
module dhi_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          sel,
  input logic [1:0]    mode,
  input logic          bus_oe,
  input logic [DW-1:0] bus_o,
  input logic          byte_valid
);
  // R2: deselected cycle yields no byte and no drive next cycle
  a_r2_idle_no_byte: assert property (@(posedge clk) disable iff (!rst_ok)
    !sel |=> !byte_valid);
  a_r2_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_ok)
    !sel |=> !bus_oe);
  // R7: serial mode never drives the pins
  a_r7_serial_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == 2'd2) |-> !bus_oe);
  // R4: undriven bus reads as zero
  a_r4_bus_zero_undriven: assert property (@(posedge clk) disable iff (!rst_ok)
    !bus_oe |-> (bus_o == '0));
  // R10: valid lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    byte_valid |=> !byte_valid);
  // R9: mode holds once reset is gone
  a_r9_strap_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> $stable(mode));
endmodule

bind dhi_top dhi_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_ok(rst_q), .sel(sel_s), .mode(mode_q),
  .bus_oe(bus_oe), .bus_o(bus_o), .byte_valid(byte_valid)
);

// File: tb/dhi_top_test.sv
module dhi_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, strap_par, strap_m68, cs_n, cs, rd_e, wr_rw, dc;
  logic [7:0] bus_i, bus_o, rd_data, byte_data;
  logic       bus_oe, byte_valid, byte_is_data;

  int nchk = 0;
  int nerr = 0;
  int pulses = 0;
  bit done = 0;

  dhi_top uut (
    .clk(clk), .rst_n(rst_n), .strap_par(strap_par), .strap_m68(strap_m68),
    .cs_n(cs_n), .cs(cs), .rd_e(rd_e), .wr_rw(wr_rw), .dc(dc),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .rd_data(rd_data),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_data(byte_is_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (byte_valid === 1'b1) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic do_reset(input logic par, input logic m68);
    @(negedge clk);
    rst_n = 0; strap_par = par; strap_m68 = m68;
    cs_n = 1; cs = 0; rd_e = m68 ? 1'b0 : 1'b1; wr_rw = 1; dc = 0; bus_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 valid", byte_valid, 0);
    chk("R1 oe", bus_oe, 0);
    chk("R1 bus", bus_o, 0);
    cs_n = 0; cs = 1;
    repeat (3) @(negedge clk);
  endtask

  // Expect a byte three clocks after the strobe edge driven at the last negedge.
  task automatic expect_byte(input string req, input logic [7:0] v, input logic d);
    repeat (3) @(posedge clk);
    #1;
    chk({req, " valid"}, byte_valid, 1);
    chk({req, " data"}, byte_data, v);
    chk({req, " R10 flag"}, byte_is_data, d);
    @(posedge clk); #1;
    chk("R10 one-cycle", byte_valid, 0);
    @(negedge clk);
  endtask

  task automatic w80_raw(input logic [7:0] v, input logic d);
    @(negedge clk); bus_i = v; dc = d; wr_rw = 0;
    repeat (2) @(negedge clk); wr_rw = 1;
  endtask

  task automatic w68_raw(input logic [7:0] v, input logic d, input logic rw);
    @(negedge clk); bus_i = v; dc = d; wr_rw = rw; rd_e = 1;
    repeat (2) @(negedge clk); rd_e = 0;
  endtask

  task automatic sbit(input logic b, input logic [5:0] junk);
    @(negedge clk); bus_i = {b, 1'b0, junk};
    repeat (2) @(negedge clk); bus_i[6] = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int pre;
    rd_data = 8'h00;
    rst_n = 0; strap_par = 1; strap_m68 = 0;
    cs_n = 1; cs = 0; rd_e = 1; wr_rw = 1; dc = 0; bus_i = 0;

    // ---- 8080 mode ----
    do_reset(1, 0);
    for (int i = 0; i < 512; i++) begin
      w80_raw(i[7:0], i[8]);
      expect_byte("R3 8080 write", i[7:0], i[8]);
    end
    for (int i = 0; i < 8; i++) begin
      rd_data = 8'h1 << i;
      @(negedge clk); rd_e = 0;
      repeat (3) @(posedge clk); #1;
      chk("R4 read oe", bus_oe, 1);
      chk("R4 read data", bus_o, 8'h1 << i);
      @(negedge clk); rd_e = 1;
      repeat (3) @(posedge clk); #1;
      chk("R4 release oe", bus_oe, 0);
      chk("R4 release bus", bus_o, 0);
    end
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      cs_n = (c != 0); cs = (c == 2);
      repeat (3) @(negedge clk);
      pre = pulses;
      w80_raw(8'hA5, 1);
      repeat (6) @(negedge clk);
      chk("R2 deselected write", pulses, pre);
      rd_e = 0;
      repeat (4) @(negedge clk);
      chk("R2 deselected read oe", bus_oe, 0);
      rd_e = 1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk); cs_n = 0; cs = 1;
    repeat (3) @(negedge clk);
    // straps change after reset: still 8080
    strap_par = 0; strap_m68 = 1;
    repeat (3) @(negedge clk);
    w80_raw(8'h3C, 0);
    expect_byte("R9 strap ignored", 8'h3C, 0);

    // ---- 6800 mode ----
    do_reset(1, 1);
    for (int i = 0; i < 512; i++) begin
      w68_raw(i[7:0] ^ 8'h5A, i[8], 0);
      expect_byte("R5 6800 write", i[7:0] ^ 8'h5A, i[8]);
    end
    pre = pulses;
    w68_raw(8'hFF, 1, 1);
    repeat (6) @(negedge clk);
    chk("R5 read pulse no byte", pulses, pre);
    for (int i = 0; i < 4; i++) begin
      rd_data = 8'h81 + 8'(i * 17);
      @(negedge clk); wr_rw = 1; rd_e = 1;
      repeat (3) @(posedge clk); #1;
      chk("R6 read oe", bus_oe, 1);
      chk("R6 read data", bus_o, 8'h81 + 8'(i * 17));
      @(negedge clk); rd_e = 0;
      repeat (3) @(posedge clk); #1;
      chk("R6 release", bus_oe, 0);
    end
    @(negedge clk); wr_rw = 0; rd_e = 1;
    repeat (4) @(negedge clk);
    chk("R6 write dir no drive", bus_oe, 0);
    rd_e = 0;
    repeat (6) @(negedge clk);

    // ---- serial mode ----
    do_reset(0, 0);
    @(negedge clk); rd_e = 0; wr_rw = 0;
    for (int i = 0; i < 512; i++) begin
      pre = pulses;
      dc = i[8];
      for (int b = 7; b >= 0; b--) sbit(i[b], 6'(~i));
      @(posedge clk); #1;
      chk("R7 serial valid", byte_valid, 1);
      chk("R7 serial data", byte_data, i[7:0]);
      chk("R7 R10 serial flag", byte_is_data, i[8]);
      chk("R7 no early byte", pulses, pre);
      chk("R7 no drive", bus_oe, 0);
      @(posedge clk); #1;
      chk("R10 serial one-cycle", byte_valid, 0);
    end
    // partial byte then deselect
    for (int b = 0; b < 3; b++) sbit(1'b1, 6'h3F);
    @(negedge clk); bus_i = 0; cs_n = 1;
    repeat (4) @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    pre = pulses;
    dc = 1;
    for (int b = 7; b >= 0; b--) sbit(b < 4, 6'h00);
    @(posedge clk); #1;
    chk("R8 restart valid", byte_valid, 1);
    chk("R8 restart data", byte_data, 8'h0F);
    chk("R8 single byte", pulses, pre);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule